// File: doc/BRIEF.md
# Byte-Handshake I2C Master Controller

This block is an I2C bus master that software drives one byte at a time through four 32-bit registers on a simple valid/ready bus. Software loads the data register and writes the status register to begin a transfer. The controller then generates a START condition and shifts out the first byte, which is the address byte. It clocks the ninth (acknowledge) bit, records what it saw, and raises a pending flag. SCL stays low while that flag is set. Software reacts, either by loading the next byte or by requesting STOP, and then writes the flag back to zero to let the bus move on.

In receive mode the bytes after the address byte are shifted in MSB first and land in the data register. During the acknowledge slot the controller drives ACK or NACK, chosen by a control bit. A mismatch between a driven 1 and a sampled 0 on SDA marks lost arbitration and frees the bus. SCL is derived from the core clock through a coarse prescaler of 16 or 512 and a fine factor of 1 to 16. Both lines are open-drain: an output of 1 pulls the line low.

Top module: `i2cb_ctrl`

## Requirements
- R1: After reset the control register (offset 0x00) and status register (offset 0x04) read 0, irq is 0 and neither bus line is pulled.
- R2: Control bits are ack_en[7], prescale select[6], irq_en[5], pending[4] and scale[3:0]. The own-address register at 0x08 and the data register at 0x0C read back what was written. Any other offset reads 0.
- R3: After the ninth SCL clock of every byte, pending (control bit 4) sets and SCL is held low until software writes pending to 0. Writing 1 to pending never sets it.
- R4: irq is high exactly when both pending and irq_en are set.
- R5: Writing the status register with mode[7:6] = 1x, enable[4] = 1 and busy[5] = 1 while idle does three things: SDA falls while SCL is high, busy reads 1, and the data register is sent MSB first. SDA does not change while SCL is high during a bit.
- R6: Status bit 0 holds the SDA level sampled in the acknowledge slot, where 1 means no ACK.
- R7: In master receive (mode 10), bytes after the address byte are assembled MSB first into the data register. The controller pulls SDA low in the acknowledge slot when ack_en is 1 and releases it when ack_en is 0.
- R8: Writing busy = 0 while busy, then clearing pending, produces STOP: SDA rises while SCL is high. The controller then clears busy and returns mode[7:6] to 00.
- R9: Each SCL half-period lasts P·(scale+1)/2 core cycles, where P is 16 when control bit 6 is 0 and 512 when it is 1.
- R10: If SDA reads 0 while the controller transmits a 1, status bit 3 (arbitration lost) sets, busy clears and both lines are released. Bit 3 clears at the next START.
- R11: Writing status enable (bit 4) to 0 aborts any transfer, releases both lines and clears busy.
- R12: While SCL is held low between transmitted bytes, writing the data register puts its bit 7 on SDA at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Access accepted this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid while a read is requested |
| irq | output | 1 | Level interrupt |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that software changes the scale, prescale and ack_en fields only while SCL is held between bytes or while the bus is idle. They also assume that a START request never arrives in the same cycle as the end of a STOP. The directed bench writes control fields only after it has seen pending set, or before it issues a START. It waits for busy to clear before it begins the next transfer. The bench's slave model changes SDA only while SCL is low, except when it deliberately forces SDA low to provoke arbitration loss.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_LO, ST_HI, ST_HOLD, ST_STP_LO, ST_STP_HI
  } eng_st_t;

  localparam int SCALE_W  = 4;
  localparam int BYTE_W   = 8;
  localparam logic [4:0] OFF_CTRL = 5'h00;
  localparam logic [4:0] OFF_STAT = 5'h04;
  localparam logic [4:0] OFF_OWN  = 5'h08;
  localparam logic [4:0] OFF_DATA = 5'h0C;
endpackage

// File: rtl/i2cb_clkdiv.sv
module i2cb_clkdiv #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int SCW    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           presc,
  input  logic [SCW-1:0] scale,
  output logic           tick
);
  localparam int HALF_LO = PRE_LO / 2;
  localparam int HALF_HI = PRE_HI / 2;
  localparam int CW      = $clog2(HALF_HI * (1 << SCW) + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim   = (presc ? CW'(HALF_HI) : CW'(HALF_LO)) * (CW'(scale) + CW'(1)) - CW'(1);
    tick  = en && (cnt_q >= lim);
    cnt_d = (!en || tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              release_i,
  input  logic              stop_req,
  input  logic              tick,
  input  logic              rx_mode,
  input  logic              ack_en,
  input  logic              sda_in,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              active,
  output logic              scl_low,
  output logic              sda_low,
  output logic              byte_done,
  output logic              ack_bit,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              stop_done,
  output logic              arb_lost
);
  localparam int BCW = $clog2(BYTE_W + 1);

  eng_st_t           state_q, state_d;
  logic [BCW-1:0]    bitcnt_q, bitcnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              istx_q, istx_d;
  logic              ack_slot;

  assign ack_slot = (bitcnt_q == BCW'(BYTE_W));

  always_comb begin
    state_d   = state_q;
    bitcnt_d  = bitcnt_q;
    sh_d      = sh_q;
    istx_d    = istx_q;
    byte_done = 1'b0;
    rx_load   = 1'b0;
    stop_done = 1'b0;
    arb_lost  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_START; sh_d = tx_byte; istx_d = 1'b1; bitcnt_d = '0;
      end
      ST_START: if (tick) state_d = ST_LO;
      ST_LO:    if (tick) state_d = ST_HI;
      ST_HI: if (tick) begin
        if (ack_slot) begin
          byte_done = 1'b1;
          rx_load   = !istx_q;
          state_d   = ST_HOLD;
        end else if (istx_q && sh_q[BYTE_W-1] && !sda_in) begin
          arb_lost = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          sh_d     = {sh_q[BYTE_W-2:0], sda_in};
          bitcnt_d = bitcnt_q + BCW'(1);
          state_d  = ST_LO;
        end
      end
      ST_HOLD: if (release_i) begin
        if (stop_req) state_d = ST_STP_LO;
        else begin
          state_d = ST_LO; sh_d = tx_byte; istx_d = !rx_mode; bitcnt_d = '0;
        end
      end
      ST_STP_LO: if (tick) state_d = ST_STP_HI;
      ST_STP_HI: if (tick) begin
        state_d = ST_IDLE; stop_done = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (abort && !start) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      sh_q     <= '0;
      istx_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      sh_q     <= sh_d;
      istx_q   <= istx_d;
    end
  end

  always_comb begin
    active  = (state_q != ST_IDLE) && (state_q != ST_HOLD);
    scl_low = (state_q == ST_LO) || (state_q == ST_HOLD) || (state_q == ST_STP_LO);
    unique case (state_q)
      ST_START, ST_STP_LO, ST_STP_HI: sda_low = 1'b1;
      ST_LO, ST_HI: sda_low = ack_slot ? (!istx_q && ack_en) : (istx_q && !sh_q[BYTE_W-1]);
      ST_HOLD: sda_low = !rx_mode && !tx_byte[BYTE_W-1];
      default: sda_low = 1'b0;
    endcase
  end

  assign ack_bit = sda_in;
  assign rx_byte = sh_q;

  // R5: data on SDA stays put for the whole high phase of a bit
  a_r5_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HI && $past(state_q) == ST_HI) |-> $stable(sda_low));

  // R3: nine clocks per byte, never more
  a_r3_bitcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= BCW'(BYTE_W));
endmodule

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl
  import i2cb_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  output logic          bus_ready,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          scl_pull,
  output logic          sda_pull,
  input  logic          sda_in
);
  logic                ack_en_q, presc_q, irq_en_q, pend_q;
  logic [SCALE_W-1:0]  scale_q;
  logic [1:0]          mode_q;
  logic                busy_q, en_q, arb_q, last_q, stop_req_q;
  logic [BYTE_W-1:0]   own_q, data_q;

  logic                ack_en_d, presc_d, irq_en_d, pend_d;
  logic [SCALE_W-1:0]  scale_d;
  logic [1:0]          mode_d;
  logic                busy_d, en_d, arb_d, last_d, stop_req_d;
  logic [BYTE_W-1:0]   own_d, data_d;

  logic wr, wr_ctrl, wr_stat, wr_own, wr_data, cmd_start, release_c;
  logic eng_active, eng_scl_low, eng_sda_low, byte_done, ack_bit, rx_load;
  logic stop_done, arb_lost, tick;
  logic [BYTE_W-1:0] rx_byte;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DW-1:BYTE_W];
  assign bus_ready    = bus_valid;
  assign wr        = bus_valid && bus_write;
  assign wr_ctrl   = wr && (bus_addr == AW'(OFF_CTRL));
  assign wr_stat   = wr && (bus_addr == AW'(OFF_STAT));
  assign wr_own    = wr && (bus_addr == AW'(OFF_OWN));
  assign wr_data   = wr && (bus_addr == AW'(OFF_DATA));
  assign cmd_start = wr_stat && bus_wdata[4] && bus_wdata[5] && bus_wdata[7] && !busy_q;
  assign release_c = wr_ctrl && !bus_wdata[4] && pend_q;

  i2cb_clkdiv #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .SCW(SCALE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(eng_active), .presc(presc_q),
    .scale(scale_q), .tick(tick));

  i2cb_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .abort(!en_q),
    .release_i(release_c), .stop_req(stop_req_q), .tick(tick),
    .rx_mode(!mode_q[0]), .ack_en(ack_en_q), .sda_in(sda_in), .tx_byte(data_q),
    .active(eng_active), .scl_low(eng_scl_low), .sda_low(eng_sda_low),
    .byte_done(byte_done), .ack_bit(ack_bit), .rx_load(rx_load), .rx_byte(rx_byte),
    .stop_done(stop_done), .arb_lost(arb_lost));

  always_comb begin
    ack_en_d = ack_en_q; presc_d = presc_q; irq_en_d = irq_en_q; pend_d = pend_q;
    scale_d = scale_q; mode_d = mode_q; busy_d = busy_q; en_d = en_q; arb_d = arb_q;
    last_d = last_q; stop_req_d = stop_req_q; own_d = own_q; data_d = data_q;
    if (wr_ctrl) begin
      ack_en_d = bus_wdata[7];
      presc_d  = bus_wdata[6];
      irq_en_d = bus_wdata[5];
      scale_d  = bus_wdata[SCALE_W-1:0];
      if (!bus_wdata[4]) pend_d = 1'b0;
    end
    if (wr_stat) begin
      mode_d = bus_wdata[7:6];
      en_d   = bus_wdata[4];
      if (!bus_wdata[4]) begin
        busy_d = 1'b0; stop_req_d = 1'b0;
      end else if (cmd_start) begin
        busy_d = 1'b1; arb_d = 1'b0; pend_d = 1'b0; stop_req_d = 1'b0;
      end else if (!bus_wdata[5] && busy_q) begin
        stop_req_d = 1'b1;
      end
    end
    if (wr_own)  own_d  = bus_wdata[BYTE_W-1:0];
    if (wr_data) data_d = bus_wdata[BYTE_W-1:0];
    else if (rx_load) data_d = rx_byte;
    if (byte_done) begin
      pend_d = 1'b1; last_d = ack_bit;
    end
    if (stop_done) begin
      busy_d = 1'b0; mode_d = 2'b00; stop_req_d = 1'b0;
    end
    if (arb_lost) begin
      arb_d = 1'b1; busy_d = 1'b0; stop_req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en_q <= 1'b0; presc_q <= 1'b0; irq_en_q <= 1'b0; pend_q <= 1'b0;
      scale_q <= '0; mode_q <= 2'b00; busy_q <= 1'b0; en_q <= 1'b0; arb_q <= 1'b0;
      last_q <= 1'b0; stop_req_q <= 1'b0; own_q <= '0; data_q <= '0;
    end else begin
      ack_en_q <= ack_en_d; presc_q <= presc_d; irq_en_q <= irq_en_d; pend_q <= pend_d;
      scale_q <= scale_d; mode_q <= mode_d; busy_q <= busy_d; en_q <= en_d; arb_q <= arb_d;
      last_q <= last_d; stop_req_q <= stop_req_d; own_q <= own_d; data_q <= data_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFF_CTRL))
      bus_rdata[BYTE_W-1:0] = {ack_en_q, presc_q, irq_en_q, pend_q, scale_q};
    else if (bus_addr == AW'(OFF_STAT))
      bus_rdata[BYTE_W-1:0] = {mode_q, busy_q, en_q, arb_q, 2'b00, last_q};
    else if (bus_addr == AW'(OFF_OWN))
      bus_rdata[BYTE_W-1:0] = own_q;
    else if (bus_addr == AW'(OFF_DATA))
      bus_rdata[BYTE_W-1:0] = data_q;
  end

  assign irq      = pend_q && irq_en_q;
  assign scl_pull = en_q && eng_scl_low;
  assign sda_pull = en_q && eng_sda_low;

  // R3: a pending byte keeps SCL low
  a_r3_scl_held: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && busy_q && en_q) |-> scl_pull);

  // R3: end of a byte raises pending
  a_r3_pend_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> pend_q);

  // R8: finished STOP frees the bus and leaves master mode
  a_r8_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> (!busy_q && mode_q == 2'b00));

  // R10: lost arbitration is flagged and drops busy
  a_r10_arb_flag: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> (arb_q && !busy_q));
endmodule

// File: tb/sim_i2cb_ctrl.sv
module sim_i2cb_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_valid, bus_write, bus_ready, irq, scl_pull, sda_pull;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  logic       slave_drv, arb_force, slave_ack, slv_tx;
  logic [7:0] slv_byte;
  wire scl_line = !scl_pull;
  wire sda_line = !(sda_pull | slave_drv | arb_force);

  i2cb_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .sda_in(sda_line));

  int nchk = 0, nfail = 0;
  int cyc, rise_cyc, last_period, start_cnt, stop_cnt;
  logic [3:0] bitpos;
  logic [7:0] mon_byte;
  logic       mon_ack, scl_p, sda_p;

  // bus monitor and slave model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 0; rise_cyc <= 0; last_period <= 0; start_cnt <= 0; stop_cnt <= 0;
      bitpos <= 4'd0; mon_byte <= 8'h00; mon_ack <= 1'b0;
      scl_p <= 1'b1; sda_p <= 1'b1; slave_drv <= 1'b0;
    end else begin
      cyc   <= cyc + 1;
      scl_p <= scl_line;
      sda_p <= sda_line;
      if (scl_line && scl_p && sda_p && !sda_line) begin
        start_cnt <= start_cnt + 1; bitpos <= 4'd0;
      end
      if (scl_line && scl_p && !sda_p && sda_line) stop_cnt <= stop_cnt + 1;
      if (scl_line && !scl_p) begin
        last_period <= cyc - rise_cyc;
        rise_cyc    <= cyc;
        if (bitpos == 4'd8) begin
          mon_ack <= sda_line; bitpos <= 4'd0;
        end else begin
          mon_byte <= {mon_byte[6:0], sda_line}; bitpos <= bitpos + 4'd1;
        end
      end
      if (!scl_line)
        slave_drv <= (bitpos == 4'd8) ? (!slv_tx && slave_ack)
                                      : (slv_tx && !slv_byte[3'd7 - bitpos[2:0]]);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_pend(input string req);
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(5'h00, d);
      if (d[4]) return;
    end
    chk({req, " pending timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      bus_rd(5'h04, d);
      if (!d[5]) return;
    end
    chk({req, " busy timeout"}, 0, 1);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(5'h00, d); chk("R1 ctrl", d, 0);
    bus_rd(5'h04, d); chk("R1 status", d, 0);
    chk("R1 lines", {irq, scl_pull, sda_pull}, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_wr(5'h00, 32'hB3);
    bus_rd(5'h00, d); chk("R2 ctrl readback / R3 pending not settable", d, 32'hA3);
    chk("R4 irq low without pending", irq, 0);
    bus_wr(5'h08, 32'h5A);
    bus_rd(5'h08, d); chk("R2 own address", d, 32'h5A);
    bus_wr(5'h0C, 32'h77);
    bus_rd(5'h0C, d); chk("R2 data readback", d, 32'h77);
    bus_rd(5'h14, d); chk("R2 unmapped", d, 0);
    bus_wr(5'h00, 32'h00);
  endtask

  task automatic t_write;
    logic [31:0] d;
    int s0, p0;
    slave_ack = 1'b1;
    bus_wr(5'h00, 32'h20);
    bus_wr(5'h0C, 32'hA4);
    s0 = start_cnt; p0 = stop_cnt;
    bus_wr(5'h04, 32'hF0);
    bus_rd(5'h04, d); chk("R5 busy after start", d[5], 1);
    wait_pend("R3");
    chk("R5 start seen", start_cnt - s0, 1);
    chk("R5 address byte", mon_byte, 8'hA4);
    bus_rd(5'h04, d); chk("R6 ack seen", d[0], 0);
    chk("R4 irq with pending", irq, 1);
    chk("R9 period p16 s0", last_period, 16);
    repeat (50) @(negedge clk);
    chk("R3 scl held low", scl_pull, 1);
    bus_wr(5'h0C, 32'h3C);
    chk("R12 bit7 on sda", {scl_pull, sda_pull}, 2'b11);
    bus_wr(5'h00, 32'h20);
    chk("R4 irq drops", irq, 0);
    wait_pend("R5");
    chk("R5 data byte", mon_byte, 8'h3C);
    slave_ack = 1'b0;
    bus_wr(5'h0C, 32'hC5);
    bus_wr(5'h00, 32'h20);
    wait_pend("R6");
    bus_rd(5'h04, d); chk("R6 nack seen", d[0], 1);
    slave_ack = 1'b1;
    bus_wr(5'h04, 32'hD0);
    bus_wr(5'h00, 32'h20);
    wait_idle("R8");
    chk("R8 stop seen", stop_cnt - p0, 1);
    bus_rd(5'h04, d); chk("R8 mode and busy cleared", d[7:5], 0);
  endtask

  task automatic t_read;
    logic [31:0] d;
    int p0;
    bus_wr(5'h00, 32'h81);
    bus_wr(5'h0C, 32'hA5);
    p0 = stop_cnt;
    bus_wr(5'h04, 32'hB0);
    wait_pend("R7");
    chk("R7 address in rx mode", mon_byte, 8'hA5);
    slv_tx = 1'b1; slv_byte = 8'h96;
    bus_wr(5'h00, 32'h81);
    wait_pend("R7");
    bus_rd(5'h0C, d); chk("R7 received byte", d, 32'h96);
    chk("R7 master ack", mon_ack, 0);
    chk("R9 period p16 s1", last_period, 32);
    slv_byte = 8'h3B;
    bus_wr(5'h00, 32'h01);
    wait_pend("R7");
    bus_rd(5'h0C, d); chk("R7 last byte", d, 32'h3B);
    chk("R7 master nack", mon_ack, 1);
    slv_tx = 1'b0;
    bus_wr(5'h04, 32'h90);
    bus_wr(5'h00, 32'h01);
    wait_idle("R8");
    chk("R8 stop after read", stop_cnt - p0, 1);
  endtask

  task automatic t_presc;
    bus_wr(5'h00, 32'h40);
    bus_wr(5'h0C, 32'h00);
    bus_wr(5'h04, 32'hF0);
    wait_pend("R9");
    chk("R9 period p512 s0", last_period, 512);
    bus_wr(5'h04, 32'hD0);
    bus_wr(5'h00, 32'h40);
    wait_idle("R9");
  endtask

  task automatic t_arb;
    logic [31:0] d;
    bus_wr(5'h00, 32'h00);
    bus_wr(5'h0C, 32'hA4);
    bus_wr(5'h04, 32'hF0);
    wait_pend("R10");
    arb_force = 1'b1;
    bus_wr(5'h0C, 32'hFF);
    bus_wr(5'h00, 32'h00);
    wait_idle("R10");
    bus_rd(5'h04, d); chk("R10 arbitration flag", d[3], 1);
    chk("R10 lines released", {scl_pull, sda_pull}, 0);
    arb_force = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr(5'h0C, 32'h00);
    bus_wr(5'h04, 32'hF0);
    bus_rd(5'h04, d); chk("R10 flag clears at start", d[3], 0);
    repeat (40) @(negedge clk);
    bus_wr(5'h04, 32'h00);
    chk("R11 lines released", {scl_pull, sda_pull}, 0);
    bus_rd(5'h04, d); chk("R11 busy cleared", d[5], 0);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    arb_force = 1'b0; slave_ack = 1'b1; slv_tx = 1'b0; slv_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_write();
    t_read();
    t_presc();
    t_arb();
    finish_run();
  end
endmodule